// File: doc/BRIEF.md
# Two-Level Hardware Breakpoint Trigger

The unit watches every bus beat and every instruction address that enters decode, and compares them against a set of programmable breakpoint registers. The address comparator can test for one exact value, for an inclusive window, or for anything outside that window. It can also require a given transfer type and size. The data comparator works on the full 32-bit word, on one 16-bit half, or on one byte lane. It has a per-bit ignore mask and a sense-inversion bit. The instruction-address comparator has its own mask and can fire either on a match or on a mismatch.

A configuration register enables comparators for a first level and, optionally, a second level. When a second level is enabled, the unit waits for the first condition and only then starts to watch for the second. Progress is visible as a 4-bit status code. When the final level fires, the unit always raises a trace indication for one cycle. Depending on the configured response, it also raises a debug-interrupt pulse or a halt pulse. A flag tells whether the trigger was precise, meaning it came from an instruction address, or imprecise, meaning it came from a bus beat.

The observed bus and instruction streams carry a valid strobe and no ready. The unit only observes and never applies back-pressure. Every beat with its valid high is evaluated in the cycle it is presented. Registers are loaded through a single write port that is tagged with its origin: the external debug port or the core.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: After reset, status reads 0000, all trigger outputs are low, and every breakpoint register is zero.
- R2: A write with `wr_en` high loads the register picked by `wr_sel`: 0 configuration, 1 low address, 2 high address, 3 attribute, 4 data value, 5 data mask, 6 instruction-address value, 7 instruction-address mask. The new value takes effect on the following cycle.
- R3: Configuration bits [9:8] pick the address test: 00 or 11 means equal to the low register; 01 means inside the inclusive window from the low register to the high register; 10 means outside that window. A bus beat is considered only while `bus_valid` is high.
- R4: With configuration bit 16 set, an address hit also requires `{bus_size, bus_type}` to equal attribute bits [5:0], with attribute bits [13:8] as a mask in which a 1 ignores the matching bit.
- R5: Configuration bits [11:10] pick the data width to compare: 00 full word, 01 half, 10 byte. Bits [13:12] give the lane index. Byte lane k is bits 8k+7:8k. The half is selected by index bit 1. A 1 in the data mask excludes that bit from the comparison.
- R6: Configuration bit 14 inverts the data result, so a hit means inequality. When address and data are both enabled for a level, both must hit on the same beat.
- R7: The instruction-address comparator ignores bits set in its mask. Configuration bit 15 makes it fire on a mismatch instead of a match. It is evaluated only while `pc_valid` is high. A trigger from this source sets `trig_precise`; a trigger from a bus beat clears it.
- R8: Status codes are 0000 (off), 0001 (waiting for level 1), 0010 (level 1 triggered), 0101 (waiting for level 2) and 0110 (level 2 triggered). Configuration bits [2:0] enable level 1 (bit 0 address, bit 1 data, bit 2 instruction address). With no level-1 enable set, the status is 0000 and all matches are ignored.
- R9: Configuration bits [5:3] enable level 2, using the same bit order as level 1. When any of them is set, a level-1 hit moves the status to 0101 without triggering, and a level-2 condition is ignored until that point.
- R10: Configuration bits [7:6] pick the response: 01 debug interrupt, 10 halt, 00 or 11 trace only. `trig_trace` pulses on every trigger. `trig_irq` or `trig_halt` pulses in the same cycle, according to the response.
- R11: Configuration bit 31 locks the registers against writes from the core; while it is set, such writes change nothing. Only a debug-port write changes bit 31. A core write to the configuration register leaves bit 31 as it was.
- R12: An accepted configuration write restarts the sequence at 0001, or at 0000 when level 1 is disabled. Once triggered, the status holds and further matches cause no pulse until the next accepted configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_from_dbg | input | 1 | 1: write from the debug port, 0: write from the core |
| wr_sel | input | 3 | Register select |
| wr_data | input | DW | Write data |
| bus_valid | input | 1 | Bus beat valid |
| bus_addr | input | AW | Bus beat address |
| bus_data | input | DW | Bus beat data |
| bus_size | input | 2 | Bus beat operand size |
| bus_type | input | 4 | Bus beat transfer type |
| pc_valid | input | 1 | Instruction address valid |
| pc_addr | input | AW | Address of the instruction in decode |
| status | output | 4 | Sequence status code |
| trig_trace | output | 1 | Trigger indication for the trace port |
| trig_irq | output | 1 | Debug interrupt pulse |
| trig_halt | output | 1 | Halt request pulse |
| trig_precise | output | 1 | Trigger came from the instruction-address comparator |

## Verification
The hardest state to reach is the second-level wait. The stimulus first loads an address condition for level 1 and an instruction-address condition for level 2. It then presents the level-2 instruction address before any bus beat has hit, and checks that the status stays at 0001. Only then does it send the level-1 bus beat and repeat the instruction address, and it checks the interrupt pulse. The lock is reached in the same way, from the ports alone. A core write that was dropped is shown by the old breakpoint address still triggering. A dropped configuration write is shown by the held status.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [3:0] {
    ST_OFF   = 4'b0000,
    ST_WAIT1 = 4'b0001,
    ST_HIT1  = 4'b0010,
    ST_WAIT2 = 4'b0101,
    ST_HIT2  = 4'b0110
  } seq_state_e;

  typedef enum logic [1:0] {
    RSP_TRACE = 2'b00,
    RSP_IRQ   = 2'b01,
    RSP_HALT  = 2'b10,
    RSP_TRC2  = 2'b11
  } resp_e;

  typedef enum logic [1:0] {
    AM_EQ   = 2'b00,
    AM_IN   = 2'b01,
    AM_OUT  = 2'b10,
    AM_EQ2  = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    LW_FULL = 2'b00,
    LW_HALF = 2'b01,
    LW_BYTE = 2'b10,
    LW_RSV  = 2'b11
  } lane_w_e;

  typedef enum logic [2:0] {
    SEL_CFG   = 3'd0,
    SEL_ALO   = 3'd1,
    SEL_AHI   = 3'd2,
    SEL_ATTR  = 3'd3,
    SEL_DVAL  = 3'd4,
    SEL_DMASK = 3'd5,
    SEL_PVAL  = 3'd6,
    SEL_PMASK = 3'd7
  } reg_sel_e;

  // configuration field positions
  localparam int CF_L1     = 0;   // 3 bits {pc,data,addr}
  localparam int CF_L2     = 3;   // 3 bits
  localparam int CF_RESP   = 6;   // 2 bits
  localparam int CF_AMODE  = 8;   // 2 bits
  localparam int CF_LWID   = 10;  // 2 bits
  localparam int CF_LIDX   = 12;  // 2 bits
  localparam int CF_DINV   = 14;
  localparam int CF_PINV   = 15;
  localparam int CF_AQUAL  = 16;
  localparam int CF_LOCK   = 31;

  localparam int ATTR_W    = 6;   // {size[1:0], type[3:0]}
  localparam int ATTR_MSK  = 8;

  typedef struct packed {
    logic pc;
    logic data;
    logic addr;
  } lvl_en_t;

endpackage

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]     addr,
  input  logic [AW-1:0]     lo,
  input  logic [AW-1:0]     hi,
  input  amode_e            mode,
  input  logic              qual_en,
  input  logic [ATTR_W-1:0] attr_val,
  input  logic [ATTR_W-1:0] attr_ign,
  input  logic [1:0]        bsize,
  input  logic [3:0]        btype,
  output logic              hit
);
  logic in_win, addr_ok, attr_ok;

  always_comb begin
    in_win = (addr >= lo) && (addr <= hi);
    unique case (mode)
      AM_IN:   addr_ok = in_win;
      AM_OUT:  addr_ok = !in_win;
      default: addr_ok = (addr == lo);
    endcase
    attr_ok = !qual_en ||
              ((({bsize, btype} ^ attr_val) & ~attr_ign) == '0);
    hit = addr_ok && attr_ok;
  end
endmodule

// File: rtl/bkpt_data_cmp.sv
module bkpt_data_cmp
  import bkpt_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int LIDX  = $clog2(LANES),
  localparam int HALVES = LANES / 2
) (
  input  logic [DW-1:0]   data,
  input  logic [DW-1:0]   val,
  input  logic [DW-1:0]   ign,
  input  lane_w_e         width,
  input  logic [LIDX-1:0] idx,
  input  logic            invert,
  output logic            hit
);
  logic [LANES-1:0]  lane_eq;
  logic [HALVES-1:0] half_eq;
  logic              raw;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_eq[k] =
      (((data[k*LANE_W +: LANE_W] ^ val[k*LANE_W +: LANE_W])
        & ~ign[k*LANE_W +: LANE_W]) == '0);
  end

  for (genvar w = 0; w < HALVES; w++) begin : g_half
    assign half_eq[w] = lane_eq[2*w] & lane_eq[2*w+1];
  end

  always_comb begin
    unique case (width)
      LW_HALF: raw = half_eq[idx[LIDX-1:1]];
      LW_BYTE: raw = lane_eq[idx];
      default: raw = &lane_eq;
    endcase
    hit = raw ^ invert;
  end
endmodule

// File: rtl/bkpt_pc_cmp.sv
module bkpt_pc_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] val,
  input  logic [AW-1:0] ign,
  input  logic          invert,
  output logic          hit
);
  logic eq;
  always_comb begin
    eq  = (((pc ^ val) & ~ign) == '0);
    hit = eq ^ invert;
  end
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
  import bkpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       restart_on,
  input  logic       two_level,
  input  resp_e      resp,
  input  logic       l1_hit,
  input  logic       l1_pc,
  input  logic       l2_hit,
  input  logic       l2_pc,
  output logic [3:0] status,
  output logic       trig_trace,
  output logic       trig_irq,
  output logic       trig_halt,
  output logic       trig_precise
);
  seq_state_e st;
  logic       fire, fire_pc;

  always_comb begin
    fire    = 1'b0;
    fire_pc = 1'b0;
    if (!restart) begin
      if (st == ST_WAIT1 && !two_level && l1_hit) begin
        fire    = 1'b1;
        fire_pc = l1_pc;
      end else if (st == ST_WAIT2 && l2_hit) begin
        fire    = 1'b1;
        fire_pc = l2_pc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_OFF;
      trig_trace   <= 1'b0;
      trig_irq     <= 1'b0;
      trig_halt    <= 1'b0;
      trig_precise <= 1'b0;
    end else begin
      trig_trace <= fire;
      trig_irq   <= fire && (resp == RSP_IRQ);
      trig_halt  <= fire && (resp == RSP_HALT);
      if (fire) trig_precise <= fire_pc;
      if (restart) begin
        st <= restart_on ? ST_WAIT1 : ST_OFF;
      end else begin
        unique case (st)
          ST_WAIT1: if (l1_hit) st <= two_level ? ST_WAIT2 : ST_HIT1;
          ST_WAIT2: if (l2_hit) st <= ST_HIT2;
          default:  st <= st;
        endcase
      end
    end
  end

  assign status = st;
endmodule

// File: rtl/bkpt_trigger_unit.sv
module bkpt_trigger_unit
  import bkpt_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int LIDX  = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_from_dbg,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [1:0]    bus_size,
  input  logic [3:0]    bus_type,
  input  logic          pc_valid,
  input  logic [AW-1:0] pc_addr,
  output logic [3:0]    status,
  output logic          trig_trace,
  output logic          trig_irq,
  output logic          trig_halt,
  output logic          trig_precise
);
  logic [31:0]         cfg;
  logic [AW-1:0]       a_lo, a_hi, p_val, p_ign;
  logic [DW-1:0]       d_val, d_ign;
  logic [ATTR_W-1:0]   at_val, at_ign;
  logic                wr_ok, cfg_load;
  logic                a_hit, d_hit, p_hit;
  lvl_en_t             en1, en2;
  logic                l1_hit, l1_pc, l2_hit, l2_pc;

  assign wr_ok    = wr_en && (wr_from_dbg || !cfg[CF_LOCK]);
  assign cfg_load = wr_ok && (wr_sel == SEL_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      a_lo   <= '0;
      a_hi   <= '0;
      at_val <= '0;
      at_ign <= '0;
      d_val  <= '0;
      d_ign  <= '0;
      p_val  <= '0;
      p_ign  <= '0;
    end else if (wr_ok) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_CFG: begin
          cfg[30:0]    <= wr_data[30:0];
          cfg[CF_LOCK] <= wr_from_dbg ? wr_data[CF_LOCK] : cfg[CF_LOCK];
        end
        SEL_ALO:   a_lo  <= wr_data[AW-1:0];
        SEL_AHI:   a_hi  <= wr_data[AW-1:0];
        SEL_ATTR: begin
          at_val <= wr_data[ATTR_W-1:0];
          at_ign <= wr_data[ATTR_MSK +: ATTR_W];
        end
        SEL_DVAL:  d_val <= wr_data;
        SEL_DMASK: d_ign <= wr_data;
        SEL_PVAL:  p_val <= wr_data[AW-1:0];
        default:   p_ign <= wr_data[AW-1:0];
      endcase
    end
  end

  bkpt_addr_cmp #(.AW(AW)) u_acmp (
    .addr     (bus_addr),
    .lo       (a_lo),
    .hi       (a_hi),
    .mode     (amode_e'(cfg[CF_AMODE +: 2])),
    .qual_en  (cfg[CF_AQUAL]),
    .attr_val (at_val),
    .attr_ign (at_ign),
    .bsize    (bus_size),
    .btype    (bus_type),
    .hit      (a_hit)
  );

  bkpt_data_cmp #(.LANES(LANES), .LANE_W(LANE_W)) u_dcmp (
    .data   (bus_data),
    .val    (d_val),
    .ign    (d_ign),
    .width  (lane_w_e'(cfg[CF_LWID +: 2])),
    .idx    (cfg[CF_LIDX +: LIDX]),
    .invert (cfg[CF_DINV]),
    .hit    (d_hit)
  );

  bkpt_pc_cmp #(.AW(AW)) u_pcmp (
    .pc     (pc_addr),
    .val    (p_val),
    .ign    (p_ign),
    .invert (cfg[CF_PINV]),
    .hit    (p_hit)
  );

  assign en1 = lvl_en_t'(cfg[CF_L1 +: 3]);
  assign en2 = lvl_en_t'(cfg[CF_L2 +: 3]);

  always_comb begin
    l1_pc  = pc_valid && en1.pc && p_hit;
    l1_hit = l1_pc ||
             (bus_valid && (en1.addr || en1.data) &&
              (!en1.addr || a_hit) && (!en1.data || d_hit));
    l2_pc  = pc_valid && en2.pc && p_hit;
    l2_hit = l2_pc ||
             (bus_valid && (en2.addr || en2.data) &&
              (!en2.addr || a_hit) && (!en2.data || d_hit));
  end

  bkpt_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (cfg_load),
    .restart_on   (wr_data[CF_L1 +: 3] != 3'b000),
    .two_level    (en2 != '0),
    .resp         (resp_e'(cfg[CF_RESP +: 2])),
    .l1_hit       (l1_hit),
    .l1_pc        (l1_pc),
    .l2_hit       (l2_hit),
    .l2_pc        (l2_pc),
    .status       (status),
    .trig_trace   (trig_trace),
    .trig_irq     (trig_irq),
    .trig_halt    (trig_halt),
    .trig_precise (trig_precise)
  );
endmodule

// File: rtl/bkpt_trigger_chk.sv
module bkpt_trigger_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_load,
  input logic [3:0] status,
  input logic       trig_trace,
  input logic       trig_irq,
  input logic       trig_halt
);
  // R8
  legal_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status inside {4'b0000, 4'b0001, 4'b0010, 4'b0101, 4'b0110});

  // R8
  trig_in_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_trace |-> (status == 4'b0010 || status == 4'b0110));

  // R10
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trig_irq, trig_halt}));

  // R10
  resp_with_trace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_irq || trig_halt) |-> trig_trace);

  // R12
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (status == 4'b0000 || status == 4'b0001));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == 4'b0010 || status == 4'b0110) && !cfg_load) |=>
      ($stable(status) && !trig_trace));

  // R9
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'b0001 && !cfg_load) |=>
      (status inside {4'b0001, 4'b0010, 4'b0101}));
endmodule

bind bkpt_trigger_unit bkpt_trigger_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .status     (status),
  .trig_trace (trig_trace),
  .trig_irq   (trig_irq),
  .trig_halt  (trig_halt)
);

// File: tb/bkpt_trigger_unit_test.sv
module bkpt_trigger_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_from_dbg = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic [1:0]  bus_size = '0;
  logic [3:0]  bus_type = '0;
  logic        pc_valid = 1'b0;
  logic [31:0] pc_addr = '0;
  logic [3:0]  status;
  logic        trig_trace, trig_irq, trig_halt, trig_precise;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  bkpt_trigger_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_from_dbg(wr_from_dbg),
    .wr_sel(wr_sel), .wr_data(wr_data), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_size(bus_size),
    .bus_type(bus_type), .pc_valid(pc_valid), .pc_addr(pc_addr),
    .status(status), .trig_trace(trig_trace), .trig_irq(trig_irq),
    .trig_halt(trig_halt), .trig_precise(trig_precise)
  );

  typedef struct packed {
    logic [31:0] cfg, lo, hi, dval, dmask;
    logic [15:0] attr;
    logic [31:0] baddr, bdata;
    logic [1:0]  bsize;
    logic [3:0]  btype;
    logic [3:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R3 exact / window / outside
    '{32'h1, 32'h3000, 32'h0, 32'h0, 32'h0, 16'h0, 32'h3000, 32'h0, 2'd0, 4'd0, 4'h2, 8'd3},
    '{32'h1, 32'h3000, 32'h0, 32'h0, 32'h0, 16'h0, 32'h3004, 32'h0, 2'd0, 4'd0, 4'h1, 8'd3},
    '{32'h101, 32'h1000, 32'h2000, 32'h0, 32'h0, 16'h0, 32'h2000, 32'h0, 2'd0, 4'd0, 4'h2, 8'd3},
    '{32'h101, 32'h1000, 32'h2000, 32'h0, 32'h0, 16'h0, 32'h2001, 32'h0, 2'd0, 4'd0, 4'h1, 8'd3},
    '{32'h201, 32'h1000, 32'h2000, 32'h0, 32'h0, 16'h0, 32'h0FFF, 32'h0, 2'd0, 4'd0, 4'h2, 8'd3},
    '{32'h201, 32'h1000, 32'h2000, 32'h0, 32'h0, 16'h0, 32'h1000, 32'h0, 2'd0, 4'd0, 4'h1, 8'd3},
    // R5 lanes and mask
    '{32'h2, 32'h0, 32'h0, 32'h12345678, 32'h0, 16'h0, 32'h0, 32'h12345678, 2'd0, 4'd0, 4'h2, 8'd5},
    '{32'h2, 32'h0, 32'h0, 32'h12345600, 32'hFF, 16'h0, 32'h0, 32'h123456AB, 2'd0, 4'd0, 4'h2, 8'd5},
    '{32'h2802, 32'h0, 32'h0, 32'h00AB0000, 32'h0, 16'h0, 32'h0, 32'hFFABFFFF, 2'd0, 4'd0, 4'h2, 8'd5},
    '{32'h2802, 32'h0, 32'h0, 32'h00AB0000, 32'h0, 16'h0, 32'h0, 32'hFFACFFFF, 2'd0, 4'd0, 4'h1, 8'd5},
    '{32'h2402, 32'h0, 32'h0, 32'h12340000, 32'h0, 16'h0, 32'h0, 32'h1234BEEF, 2'd0, 4'd0, 4'h2, 8'd5},
    '{32'h0402, 32'h0, 32'h0, 32'h12340000, 32'h0, 16'h0, 32'h0, 32'h1234BEEF, 2'd0, 4'd0, 4'h1, 8'd5},
    // R6 invert and address-with-data
    '{32'h4002, 32'h0, 32'h0, 32'h1234, 32'h0, 16'h0, 32'h0, 32'h1234, 2'd0, 4'd0, 4'h1, 8'd6},
    '{32'h4002, 32'h0, 32'h0, 32'h1234, 32'h0, 16'h0, 32'h0, 32'h1235, 2'd0, 4'd0, 4'h2, 8'd6},
    '{32'h3, 32'h3000, 32'h0, 32'h1234, 32'h0, 16'h0, 32'h3004, 32'h1234, 2'd0, 4'd0, 4'h1, 8'd6},
    '{32'h3, 32'h3000, 32'h0, 32'h1234, 32'h0, 16'h0, 32'h3000, 32'h1234, 2'd0, 4'd0, 4'h2, 8'd6},
    // R4 attribute qualification
    '{32'h10001, 32'h3000, 32'h0, 32'h0, 32'h0, 16'h0015, 32'h3000, 32'h0, 2'd1, 4'd5, 4'h2, 8'd4},
    '{32'h10001, 32'h3000, 32'h0, 32'h0, 32'h0, 16'h0015, 32'h3000, 32'h0, 2'd1, 4'd4, 4'h1, 8'd4},
    '{32'h10001, 32'h3000, 32'h0, 32'h0, 32'h0, 16'h0F15, 32'h3000, 32'h0, 2'd1, 4'd4, 4'h2, 8'd4}
  };

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic dbg, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_from_dbg = dbg; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus(input logic [31:0] a, input logic [31:0] d,
                     input logic [1:0] sz, input logic [3:0] ty, input logic v);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_data = d; bus_size = sz; bus_type = ty;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic pcev(input logic [31:0] p);
    @(negedge clk);
    pc_valid = 1'b1; pc_addr = p;
    @(negedge clk);
    pc_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 4'h0);
    chk("R1 trig", {trig_trace, trig_irq, trig_halt, trig_precise}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 registers zero: window 0..0 with level 1 on address
    wr(1, 0, 32'h101);
    bus(32'h0, 32'h0, 2'd0, 4'd0, 1'b1);
    chk("R1 regs zero", status, 4'h2);

    // vector table, loaded from the debug port (R2)
    for (int i = 0; i < NV; i++) begin
      wr(1, 1, VECS[i].lo);
      wr(1, 2, VECS[i].hi);
      wr(1, 3, {16'h0, VECS[i].attr});
      wr(1, 4, VECS[i].dval);
      wr(1, 5, VECS[i].dmask);
      wr(1, 0, VECS[i].cfg);
      bus(VECS[i].baddr, VECS[i].bdata, VECS[i].bsize, VECS[i].btype, 1'b1);
      n_chk++;
      if (status !== VECS[i].exp) begin
        n_fail++;
        $display("FAIL vec %0d (R%0d): actual %0h expected %0h", i, VECS[i].req,
                 status, VECS[i].exp);
      end
    end

    // R3 valid gating
    wr(1, 1, 32'h3000); wr(1, 0, 32'h1);
    bus(32'h3000, 32'h0, 2'd0, 4'd0, 1'b0);
    chk("R3 bus_valid low", status, 4'h1);
    // R7 bus trigger is imprecise
    bus(32'h3000, 32'h0, 2'd0, 4'd0, 1'b1);
    chk("R7 imprecise", {trig_trace, trig_precise}, 2'b10);

    // R7 instruction address compare
    wr(1, 6, 32'h8030); wr(1, 7, 32'hF); wr(1, 0, 32'h4);
    pcev(32'h8130);
    chk("R7 pc miss", status, 4'h1);
    pcev(32'h8035);
    chk("R7 pc masked hit", status, 4'h2);
    chk("R7 precise", {trig_trace, trig_precise}, 2'b11);
    wr(1, 0, 32'h8004);
    pcev(32'h8030);
    chk("R7 pc invert equal", status, 4'h1);
    pcev(32'h9000);
    chk("R7 pc invert differ", status, 4'h2);

    // R8 nothing enabled
    wr(1, 0, 32'h0);
    chk("R8 off", status, 4'h0);
    bus(32'h3000, 32'h0, 2'd0, 4'd0, 1'b1);
    chk("R8 off ignores", {status, trig_trace}, 5'h00);

    // R9 two-level: level1 address, level2 pc, interrupt response
    wr(1, 7, 32'h0); wr(1, 0, 32'h61);
    chk("R9 wait1", status, 4'h1);
    pcev(32'h8030);
    chk("R9 level2 ignored early", status, 4'h1);
    bus(32'h3000, 32'h0, 2'd0, 4'd0, 1'b1);
    chk("R9 wait2", {status, trig_trace}, 5'b01010);
    pcev(32'h8030);
    chk("R9 level2 hit", status, 4'h6);
    chk("R10 irq response", {trig_trace, trig_irq, trig_halt, trig_precise}, 4'b1101);

    // R12 hold and restart
    bus(32'h3000, 32'h0, 2'd0, 4'd0, 1'b1);
    chk("R12 hold bus", {status, trig_trace}, 5'b01100);
    pcev(32'h8030);
    chk("R12 hold pc", {status, trig_trace}, 5'b01100);
    wr(1, 0, 32'h61);
    chk("R12 restart", status, 4'h1);

    // R10 halt and trace-only responses
    wr(1, 0, 32'h81);
    bus(32'h3000, 32'h0, 2'd0, 4'd0, 1'b1);
    chk("R10 halt", {trig_trace, trig_irq, trig_halt}, 3'b101);
    wr(1, 0, 32'h1);
    bus(32'h3000, 32'h0, 2'd0, 4'd0, 1'b1);
    chk("R10 trace only", {trig_trace, trig_irq, trig_halt}, 3'b100);

    // R11 lock
    wr(1, 1, 32'h3000); wr(1, 0, 32'h80000001);
    wr(0, 1, 32'h4000);
    bus(32'h4000, 32'h0, 2'd0, 4'd0, 1'b1);
    chk("R11 core write blocked", status, 4'h1);
    bus(32'h3000, 32'h0, 2'd0, 4'd0, 1'b1);
    chk("R11 old value kept", status, 4'h2);
    wr(0, 0, 32'h0);
    chk("R11 core cfg blocked", status, 4'h2);
    wr(1, 0, 32'h1);
    chk("R11 debug unlock", status, 4'h1);
    wr(0, 1, 32'h4000);
    bus(32'h4000, 32'h0, 2'd0, 4'd0, 1'b1);
    chk("R11 core write accepted", status, 4'h2);
    wr(0, 0, 32'h80000001);
    chk("R11 core cfg restart", status, 4'h1);
    wr(0, 1, 32'h5000);
    bus(32'h5000, 32'h0, 2'd0, 4'd0, 1'b1);
    chk("R11 core cannot set lock", status, 4'h2);

    summary();
  end
endmodule